// File: doc/BRIEF.md
# Speculative Load Issue Classifier

This block sits between the load queue and the data cache port of a core that keeps speculative loads hidden from the cache hierarchy. For each load handed to it, it decides whether the access goes out as a speculative read, which leaves no visible cache state, or as an ordinary read. For a speculative read it also works out what must happen once the load is no longer speculative. The load either only has to expose its line, or it must be validated again, depending on the memory ordering model and on whether every older load in the queue has already executed.

A misaligned load is carried as two request halves, low and high. The speculative-buffer lookup is done outside this block and its per-half hit result arrives alongside the load. The block attaches the source entry of a hit to that half and, when buffer hits are allowed, marks the half so that it reads only the speculative buffer. A one-entry output register holds the classification under a valid/ready handshake, so that a cache port that refuses the request loses nothing. Two saturating counters record buffer hits and misses for speculative requests the cache actually took.

Top module: `spec_load_classifier`

## Requirements
- R1: `outSpec` is 1 exactly when `invisEn` is 1 and `readyExpose` is 0 for the captured load; otherwise the request is an ordinary read (`outSpec`=0).
- R2: `errIllegal` is 1 when a load takes the speculative path while any of `isLlsc`, `isStrict` or `isMmio` is set, and 0 otherwise.
- R3: `errDouble` is 1 when a load takes the speculative path while `specDone` is already set, and 0 otherwise.
- R4: For a speculative read, a half whose hit input is 1 gets `outSrcValid` bit 1 and its source index (`outSrcLo`/`outSrcHi`) equal to the supplied hit index. A half that misses, an absent half, or any half of an ordinary read gets bit 0 and index 0. Bit 0 is the low half and bit 1 is the high half.
- R5: `outBufOnly` for a half is 1 exactly when that half has a speculative hit (R4) and `allowBufHit` is 1.
- R6: `outSplit` equals `isSplit`, and `outIdx` equals `ldIdx`. Without a split, every high-half output (`outBufOnly[1]`, `outSrcValid[1]`, `outBufUpd[1]`) is 0.
- R7: For a speculative read under TSO (`tsoMode`=1) of a non-prefetch load, `outPost` is 2 (validate) if any older load has not executed, and 1 (expose only) if all have.
- R8: For a speculative read under relaxed ordering (`tsoMode`=0), or of a prefetch, `outPost` is 1 (expose only).
- R9: For an ordinary read, `outPost` is 0 (none) and `outExposeDone` is 1. `outBufUpd` is set for the low half and, when split, for the high half. For a speculative read, `outExposeDone` and `outBufUpd` are 0.
- R10: The older loads are the queue entries reached by walking circularly from `headIdx` up to, but not including, `ldIdx`, wrapping at the queue depth. `olderExec` bit i gives the executed state of entry i.
- R11: `inReady` is 0 only while `outValid` is 1 and `outReady` is 0. While `outReady` is 0 the presented classification holds unchanged. The counters change only in a cycle where `outValid` and `outReady` are both 1.
- R12: When a speculative request is accepted, `hitCount` grows by the number of its halves that hit and `missCount` by the number that missed. Both counters saturate at their all-ones value.
- R13: After reset, `outValid` is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A load descriptor is offered |
| inReady | output | 1 | Descriptor can be taken this cycle |
| ldIdx | input | IDXW | Load queue index of the load |
| readyExpose | input | 1 | Load is no longer speculative |
| isLlsc | input | 1 | Load-linked access |
| isStrict | input | 1 | Strictly ordered access |
| isMmio | input | 1 | Access to a memory-mapped register |
| isPrefetch | input | 1 | Data prefetch |
| isSplit | input | 1 | Misaligned load split into two halves |
| specDone | input | 1 | Load already completed a speculative read |
| headIdx | input | IDXW | Load queue head index |
| olderExec | input | DEPTH | Executed flag of each queue entry |
| invisEn | input | 1 | Invisible speculation mode enable |
| tsoMode | input | 1 | 1 = TSO ordering, 0 = relaxed |
| allowBufHit | input | 1 | Permit buffer-only access on a hit |
| hitLo | input | 1 | Speculative buffer hit, low half |
| hitLoSrc | input | SRCW | Source entry of the low-half hit |
| hitHi | input | 1 | Speculative buffer hit, high half |
| hitHiSrc | input | SRCW | Source entry of the high-half hit |
| outValid | output | 1 | Classification presented |
| outReady | input | 1 | Cache port accepts the request |
| outIdx | output | IDXW | Load index carried by both halves |
| outSpec | output | 1 | 1 = speculative read, 0 = ordinary read |
| outSplit | output | 1 | Request has a high half |
| outBufOnly | output | 2 | Per half: read speculative buffer only |
| outSrcValid | output | 2 | Per half: source index attached |
| outSrcLo | output | SRCW | Source index, low half |
| outSrcHi | output | SRCW | Source index, high half |
| outPost | output | 2 | Post-fetch action: 0 none, 1 expose, 2 validate |
| outExposeDone | output | 1 | Load marked expose-completed |
| outBufUpd | output | 2 | Per half: update speculative buffer state |
| errIllegal | output | 1 | Forbidden access on the speculative path |
| errDouble | output | 1 | Second speculative read of one load |
| hitCount | output | CNTW | Saturating buffer hit count |
| missCount | output | CNTW | Saturating buffer miss count |

## Verification
On every cycle the assertions check several invariants. A refused request stays frozen, and the counters move only on an accepted transfer and never fall. No high-half flag appears without a split. A buffer-only flag is never set without an attached source on a speculative read. An ordinary read never carries a post-fetch action. Only the bench scenarios can show the classification itself. These cover the choice between validation and expose-only, which depends on the circular older-load window and on the executed flags, the error flags for forbidden speculative accesses, the exact source indices, and the saturation point of the counters.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [1:0] {
    POST_NONE     = 2'd0,
    POST_EXPOSE   = 2'd1,
    POST_VALIDATE = 2'd2
  } postAct_t;

  typedef struct packed {
    logic capture;
    logic fire;
  } slcStrobe_t;
endpackage

// File: rtl/slc_ctrl.sv
module slc_ctrl
  import slc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output slcStrobe_t strobe
);
  logic heldQ;

  always_comb begin
    inReady        = !heldQ || outReady;
    strobe.capture = inValid && inReady;
    strobe.fire    = heldQ && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               heldQ <= 1'b0;
    else if (strobe.capture) heldQ <= 1'b1;
    else if (strobe.fire)    heldQ <= 1'b0;
  end

  assign outValid = heldQ;
endmodule

// File: rtl/slc_older_scan.sv
module slc_older_scan #(
  parameter int DEPTH = 8,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic [IDXW-1:0]  headIdx,
  input  logic [IDXW-1:0]  curIdx,
  input  logic [DEPTH-1:0] executed,
  output logic             allOlderDone
);
  localparam int DW = IDXW + 1;

  logic [DW-1:0]    curDist;
  logic [DEPTH-1:0] pending;

  always_comb begin
    if (curIdx >= headIdx) curDist = DW'(curIdx) - DW'(headIdx);
    else                   curDist = DW'(curIdx) + DW'(DEPTH) - DW'(headIdx);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [DW-1:0] entDist;
    always_comb begin
      if (IDXW'(e) >= headIdx) entDist = DW'(e) - DW'(headIdx);
      else                     entDist = DW'(e) + DW'(DEPTH) - DW'(headIdx);
      pending[e] = (entDist < curDist) && !executed[e];
    end
  end

  assign allOlderDone = (pending == '0);
endmodule

// File: rtl/slc_datapath.sv
module slc_datapath
  import slc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDXW  = $clog2(DEPTH),
  parameter int SRCW  = 4,
  parameter int CNTW  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  slcStrobe_t       strobe,
  input  logic [IDXW-1:0]  ldIdx,
  input  logic             readyExpose,
  input  logic             isLlsc,
  input  logic             isStrict,
  input  logic             isMmio,
  input  logic             isPrefetch,
  input  logic             isSplit,
  input  logic             specDone,
  input  logic [IDXW-1:0]  headIdx,
  input  logic [DEPTH-1:0] olderExec,
  input  logic             invisEn,
  input  logic             tsoMode,
  input  logic             allowBufHit,
  input  logic             hitLo,
  input  logic [SRCW-1:0]  hitLoSrc,
  input  logic             hitHi,
  input  logic [SRCW-1:0]  hitHiSrc,
  output logic [IDXW-1:0]  outIdx,
  output logic             outSpec,
  output logic             outSplit,
  output logic [1:0]       outBufOnly,
  output logic [1:0]       outSrcValid,
  output logic [SRCW-1:0]  outSrcLo,
  output logic [SRCW-1:0]  outSrcHi,
  output logic [1:0]       outPost,
  output logic             outExposeDone,
  output logic [1:0]       outBufUpd,
  output logic             errIllegal,
  output logic             errDouble,
  output logic [CNTW-1:0]  hitCount,
  output logic [CNTW-1:0]  missCount
);
  typedef struct packed {
    logic [IDXW-1:0] idx;
    logic            spec;
    logic            split;
    logic [1:0]      bufOnly;
    logic [1:0]      srcValid;
    logic [SRCW-1:0] srcLo;
    logic [SRCW-1:0] srcHi;
    postAct_t        post;
    logic            exposeDone;
    logic [1:0]      bufUpd;
    logic            eIllegal;
    logic            eDouble;
  } slcWord_t;

  logic     allOlderDone;
  slcWord_t nxt, cur;

  slc_older_scan #(.DEPTH(DEPTH), .IDXW(IDXW)) u_scan (
    .headIdx     (headIdx),
    .curIdx      (ldIdx),
    .executed    (olderExec),
    .allOlderDone(allOlderDone)
  );

  always_comb begin
    logic [1:0] halfOn;
    logic [1:0] hit;
    halfOn = {isSplit, 1'b1};
    nxt.idx   = ldIdx;
    nxt.spec  = invisEn && !readyExpose;
    nxt.split = isSplit;
    hit = nxt.spec ? ({hitHi, hitLo} & halfOn) : 2'b00;
    nxt.srcValid = hit;
    nxt.bufOnly  = allowBufHit ? hit : 2'b00;
    nxt.srcLo    = hit[0] ? hitLoSrc : '0;
    nxt.srcHi    = hit[1] ? hitHiSrc : '0;
    if (!nxt.spec)                                    nxt.post = POST_NONE;
    else if (tsoMode && !isPrefetch && !allOlderDone) nxt.post = POST_VALIDATE;
    else                                              nxt.post = POST_EXPOSE;
    nxt.exposeDone = !nxt.spec;
    nxt.bufUpd     = nxt.spec ? 2'b00 : halfOn;
    nxt.eIllegal   = nxt.spec && (isLlsc || isStrict || isMmio);
    nxt.eDouble    = nxt.spec && specDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cur <= '0;
    else if (strobe.capture) cur <= nxt;
  end

  // per-transfer counter increments, at most one per half
  logic [1:0] hitInc, missInc;
  always_comb begin
    hitInc  = 2'd0;
    missInc = 2'd0;
    if (cur.spec) begin
      hitInc  = 2'(cur.srcValid[0]) + 2'(cur.srcValid[1]);
      missInc = 2'(!cur.srcValid[0]) + 2'(cur.split && !cur.srcValid[1]);
    end
  end

  function automatic logic [CNTW-1:0] satAdd(input logic [CNTW-1:0] a, input logic [1:0] b);
    logic [CNTW:0] s;
    s = {1'b0, a} + (CNTW+1)'(b);
    return s[CNTW] ? {CNTW{1'b1}} : s[CNTW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else if (strobe.fire) begin
      hitCount  <= satAdd(hitCount, hitInc);
      missCount <= satAdd(missCount, missInc);
    end
  end

  assign outIdx        = cur.idx;
  assign outSpec       = cur.spec;
  assign outSplit      = cur.split;
  assign outBufOnly    = cur.bufOnly;
  assign outSrcValid   = cur.srcValid;
  assign outSrcLo      = cur.srcLo;
  assign outSrcHi      = cur.srcHi;
  assign outPost       = cur.post;
  assign outExposeDone = cur.exposeDone;
  assign outBufUpd     = cur.bufUpd;
  assign errIllegal    = cur.eIllegal;
  assign errDouble     = cur.eDouble;
endmodule

// File: rtl/spec_load_classifier.sv
module spec_load_classifier
  import slc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDXW  = $clog2(DEPTH),
  parameter int SRCW  = 4,
  parameter int CNTW  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [IDXW-1:0]  ldIdx,
  input  logic             readyExpose,
  input  logic             isLlsc,
  input  logic             isStrict,
  input  logic             isMmio,
  input  logic             isPrefetch,
  input  logic             isSplit,
  input  logic             specDone,
  input  logic [IDXW-1:0]  headIdx,
  input  logic [DEPTH-1:0] olderExec,
  input  logic             invisEn,
  input  logic             tsoMode,
  input  logic             allowBufHit,
  input  logic             hitLo,
  input  logic [SRCW-1:0]  hitLoSrc,
  input  logic             hitHi,
  input  logic [SRCW-1:0]  hitHiSrc,
  output logic             outValid,
  input  logic             outReady,
  output logic [IDXW-1:0]  outIdx,
  output logic             outSpec,
  output logic             outSplit,
  output logic [1:0]       outBufOnly,
  output logic [1:0]       outSrcValid,
  output logic [SRCW-1:0]  outSrcLo,
  output logic [SRCW-1:0]  outSrcHi,
  output logic [1:0]       outPost,
  output logic             outExposeDone,
  output logic [1:0]       outBufUpd,
  output logic             errIllegal,
  output logic             errDouble,
  output logic [CNTW-1:0]  hitCount,
  output logic [CNTW-1:0]  missCount
);
  slcStrobe_t strobe;

  slc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  slc_datapath #(.DEPTH(DEPTH), .IDXW(IDXW), .SRCW(SRCW), .CNTW(CNTW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .ldIdx        (ldIdx),
    .readyExpose  (readyExpose),
    .isLlsc       (isLlsc),
    .isStrict     (isStrict),
    .isMmio       (isMmio),
    .isPrefetch   (isPrefetch),
    .isSplit      (isSplit),
    .specDone     (specDone),
    .headIdx      (headIdx),
    .olderExec    (olderExec),
    .invisEn      (invisEn),
    .tsoMode      (tsoMode),
    .allowBufHit  (allowBufHit),
    .hitLo        (hitLo),
    .hitLoSrc     (hitLoSrc),
    .hitHi        (hitHi),
    .hitHiSrc     (hitHiSrc),
    .outIdx       (outIdx),
    .outSpec      (outSpec),
    .outSplit     (outSplit),
    .outBufOnly   (outBufOnly),
    .outSrcValid  (outSrcValid),
    .outSrcLo     (outSrcLo),
    .outSrcHi     (outSrcHi),
    .outPost      (outPost),
    .outExposeDone(outExposeDone),
    .outBufUpd    (outBufUpd),
    .errIllegal   (errIllegal),
    .errDouble    (errDouble),
    .hitCount     (hitCount),
    .missCount    (missCount)
  );
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int CNTW = 32,
  parameter int SRCW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic            outSpec,
  input logic            outSplit,
  input logic [1:0]      outBufOnly,
  input logic [1:0]      outSrcValid,
  input logic [SRCW-1:0] outSrcLo,
  input logic [1:0]      outPost,
  input logic [1:0]      outBufUpd,
  input logic [CNTW-1:0] hitCount,
  input logic [CNTW-1:0] missCount
);
  a_r11_ready_when_free: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  a_r11_hold_on_reject: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSpec) && $stable(outPost)
                                 && $stable(outSrcValid) && $stable(outSrcLo)));

  a_r11_count_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outReady) |=> ($stable(hitCount) && $stable(missCount)));

  a_r12_never_falls: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (hitCount >= $past(hitCount) && missCount >= $past(missCount)));

  a_r5_bufonly_needs_src: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outBufOnly != 2'b00) |-> (outSpec && ((outBufOnly & ~outSrcValid) == 2'b00)));

  a_r6_high_half_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSplit) |-> (!outBufOnly[1] && !outSrcValid[1] && !outBufUpd[1]));

  a_r9_plain_read_no_post: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSpec) |-> (outPost == 2'd0 && outSrcValid == 2'b00));
endmodule

bind spec_load_classifier slc_checker #(.CNTW(CNTW), .SRCW(SRCW)) u_slc_checker (
  .clk        (clk),
  .rstN       (rstN),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outSpec    (outSpec),
  .outSplit   (outSplit),
  .outBufOnly (outBufOnly),
  .outSrcValid(outSrcValid),
  .outSrcLo   (outSrcLo),
  .outPost    (outPost),
  .outBufUpd  (outBufUpd),
  .hitCount   (hitCount),
  .missCount  (missCount)
);

// File: tb/spec_load_classifier_bench.sv
module spec_load_classifier_bench;
  localparam int DEPTH = 4;
  localparam int IDXW  = 2;
  localparam int SRCW  = 4;
  localparam int CNTW  = 4;
  localparam int CMAX  = (1 << CNTW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, inValid, inReady, readyExpose, isLlsc, isStrict, isMmio, isPrefetch, isSplit, specDone;
  logic [IDXW-1:0] ldIdx, headIdx, outIdx;
  logic [DEPTH-1:0] olderExec;
  logic invisEn, tsoMode, allowBufHit, hitLo, hitHi, outValid, outReady, outSpec, outSplit;
  logic [SRCW-1:0] hitLoSrc, hitHiSrc, outSrcLo, outSrcHi;
  logic [1:0] outBufOnly, outSrcValid, outPost, outBufUpd;
  logic outExposeDone, errIllegal, errDouble;
  logic [CNTW-1:0] hitCount, missCount;

  spec_load_classifier #(.DEPTH(DEPTH), .SRCW(SRCW), .CNTW(CNTW)) u_spec_load_classifier (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .ldIdx(ldIdx),
    .readyExpose(readyExpose), .isLlsc(isLlsc), .isStrict(isStrict), .isMmio(isMmio),
    .isPrefetch(isPrefetch), .isSplit(isSplit), .specDone(specDone), .headIdx(headIdx),
    .olderExec(olderExec), .invisEn(invisEn), .tsoMode(tsoMode), .allowBufHit(allowBufHit),
    .hitLo(hitLo), .hitLoSrc(hitLoSrc), .hitHi(hitHi), .hitHiSrc(hitHiSrc),
    .outValid(outValid), .outReady(outReady), .outIdx(outIdx), .outSpec(outSpec),
    .outSplit(outSplit), .outBufOnly(outBufOnly), .outSrcValid(outSrcValid),
    .outSrcLo(outSrcLo), .outSrcHi(outSrcHi), .outPost(outPost),
    .outExposeDone(outExposeDone), .outBufUpd(outBufUpd), .errIllegal(errIllegal),
    .errDouble(errDouble), .hitCount(hitCount), .missCount(missCount)
  );

  int nChecks = 0;
  int nFails  = 0;
  int expHit  = 0;
  int expMiss = 0;
  bit done    = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int satInc(input int v, input int d);
    return (v + d > CMAX) ? CMAX : v + d;
  endfunction

  // one descriptor: offer, check presentation, hold one refused cycle, accept
  task automatic runOne(input bit ie, input bit re, input bit tso, input bit pf, input bit sp,
                        input bit hl, input bit hh, input bit ab, input int hd, input int ix,
                        input int ex, input bit ll, input bit st, input bit mm, input bit sd);
    bit spec, anyPending, hLo, hHi;
    int dCur, dEnt, post;
    @(negedge clk);
    invisEn = ie; readyExpose = re; tsoMode = tso; isPrefetch = pf; isSplit = sp;
    hitLo = hl; hitHi = hh; allowBufHit = ab; headIdx = IDXW'(hd); ldIdx = IDXW'(ix);
    olderExec = DEPTH'(ex); isLlsc = ll; isStrict = st; isMmio = mm; specDone = sd;
    hitLoSrc = SRCW'(ix * 3 + 1); hitHiSrc = SRCW'(ix * 5 + 2);
    inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    spec = ie && !re;
    hLo = spec && hl;
    hHi = spec && hh && sp;
    dCur = (ix - hd + DEPTH) % DEPTH;
    anyPending = 1'b0;
    for (int e = 0; e < DEPTH; e++) begin
      dEnt = (e - hd + DEPTH) % DEPTH;
      if (dEnt < dCur && !ex[e]) anyPending = 1'b1;
    end
    post = !spec ? 0 : ((tso && !pf && anyPending) ? 2 : 1);
    chk(outValid === 1'b1, "R11 valid", int'(outValid), 1);
    chk(outSpec === spec, "R1 spec", int'(outSpec), int'(spec));
    chk(errIllegal === (spec && (ll || st || mm)), "R2 illegal", int'(errIllegal), int'(spec && (ll || st || mm)));
    chk(errDouble === (spec && sd), "R3 double", int'(errDouble), int'(spec && sd));
    chk(outSrcValid === {hHi, hLo}, "R4 srcValid", int'(outSrcValid), int'({hHi, hLo}));
    chk(outSrcLo === (hLo ? SRCW'(ix * 3 + 1) : '0), "R4 srcLo", int'(outSrcLo), hLo ? (ix * 3 + 1) % 16 : 0);
    chk(outSrcHi === (hHi ? SRCW'(ix * 5 + 2) : '0), "R4 srcHi", int'(outSrcHi), hHi ? (ix * 5 + 2) % 16 : 0);
    chk(outBufOnly === ({hHi, hLo} & {ab, ab}), "R5 bufOnly", int'(outBufOnly), int'({hHi, hLo} & {ab, ab}));
    chk(outSplit === sp && outIdx === IDXW'(ix), "R6 split/index", int'(outIdx), ix);
    if (spec && tso && !pf) chk(outPost === 2'(post), "R7 tso post", int'(outPost), post);
    else if (spec)          chk(outPost === 2'(post), "R8 expose post", int'(outPost), post);
    else                    chk(outPost === 2'd0, "R9 plain post", int'(outPost), 0);
    if (spec && tso && !pf) chk(outPost === 2'(post), "R10 older window", int'(outPost), post);
    chk(outExposeDone === !spec, "R9 exposeDone", int'(outExposeDone), int'(!spec));
    chk(outBufUpd === (spec ? 2'b00 : {sp, 1'b1}), "R9 bufUpd", int'(outBufUpd), spec ? 0 : int'({sp, 1'b1}));
    chk(inReady === 1'b0, "R11 not ready", int'(inReady), 0);
    @(negedge clk);
    chk(outValid === 1'b1 && outPost === 2'(post), "R11 hold", int'(outPost), post);
    chk(hitCount === CNTW'(expHit), "R11 no count before accept", int'(hitCount), expHit);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    if (spec) begin
      expHit  = satInc(expHit, int'(hLo) + int'(hHi));
      expMiss = satInc(expMiss, int'(!hLo) + int'(sp && !hHi));
    end
    chk(outValid === 1'b0, "R11 drained", int'(outValid), 0);
    chk(hitCount === CNTW'(expHit), "R12 hits", int'(hitCount), expHit);
    chk(missCount === CNTW'(expMiss), "R12 misses", int'(missCount), expMiss);
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0; readyExpose = 0; isLlsc = 0; isStrict = 0;
    isMmio = 0; isPrefetch = 0; isSplit = 0; specDone = 0; ldIdx = 0; headIdx = 0; olderExec = 0;
    invisEn = 0; tsoMode = 0; allowBufHit = 0; hitLo = 0; hitHi = 0; hitLoSrc = 0; hitHiSrc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(outValid === 1'b0, "R13 reset valid", int'(outValid), 0);
    chk(hitCount === '0 && missCount === '0, "R13 reset counters", int'(hitCount), 0);
    // forbidden kinds on and off the speculative path
    runOne(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4'hF, 1, 0, 0, 0);
    runOne(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4'hF, 0, 1, 0, 0);
    runOne(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4'hF, 0, 0, 1, 0);
    runOne(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 4'hF, 1, 1, 1, 1);
    runOne(1, 0, 0, 0, 1, 1, 1, 1, 2, 1, 4'h0, 0, 0, 0, 1);
    // sweep of modes, hits, split and queue windows
    for (int n = 0; n < 256; n++) begin
      runOne(n[0], n[1], n[2], n[3], n[4], n[5], n[6], n[7],
             (n * 3) % DEPTH, (n / 5) % DEPTH, (n * 7) % 16, 0, 0, 0, 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule